// File: doc/BRIEF.md
# Dual-Mode PWM and Capture Timer with Dead Time

This block is a 12-bit timer that either generates pulse-width modulated drive or time-stamps edges on an input pin. A byte-wide register bus sets it up. In generation mode it drives two high-side outputs and an ADC strobe. After every counter wrap it can hold both high-side outputs off for a programmable number of clocks. In capture mode the counter runs freely, and a selected edge on the capture input copies the counter into a capture value and raises an interrupt pulse.

Control bits written while the timer runs are held in the control register and do not reach the logic at once. They are applied at the next cycle boundary. The boundary comes when the counter has wrapped and the dead-time window has also closed. Reading the control register returns the value software last wrote, not the attributes currently in force. Software can leave capture mode in one of two ways:
- Clearing the mode bit and the run bit in one write stops capture at once.
- Clearing only the mode bit defers the stop to the next boundary. The block then refuses to start again until the run bit has been written as 0.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset every register reads 0, except the period, which resets to 0xFFF. hs1_o, hs2_o, strobe_o and irq_o are 0, and cap_value is 0.
- R2: Register map: 0 = control, 1 = dead time, 2 = polarity, 3/4 = period low/high, 5/6 = duty low/high. The control bits are: bit 7 mode (0 PWM, 1 capture), bit 6 second-output enable in PWM or capture edge in capture, bit 5 first-output enable, and bit 0 run and strobe-pin enable. While stopped, writing control with bit 7 = 0 and bit 0 = 1 starts PWM at once with the counter at 0. The counter counts up by one per clock and wraps after the period value, so a cycle lasts period+1 clocks. hs1 is active while counter < duty.
- R3: The dead-time register keeps only bits 4:0, and the upper bits read as 0. After every wrap, both high-side outputs are inactive for DT clocks, where DT is that field. A DT of 0 inserts no gap.
- R4: While the timer runs, a control write changes only the readback. The new bits take effect at the first boundary after the write. A boundary is the wrap clock when DT = 0, and otherwise the last clock of the dead-time window.
- R5: Polarity bit 0 controls hs1_o, bit 1 controls strobe_o and bit 2 controls hs2_o. A polarity bit of 0 gives an active-high pin and 1 gives an active-low pin. An inactive output sits at its polarity bit.
- R6: In PWM mode, strobe_o is active for exactly one clock: the last count of each cycle. It never pulses while the timer is stopped.
- R7: In PWM mode, irq_o pulses for one clock immediately after each wrap.
- R8: Writing control with bit 7 = 1 while stopped starts capture with the counter at 0. The counter wraps only at 0xFFF. The capture input passes through a two-flop synchroniser. On the selected edge (rising if bit 6 = 0, falling if bit 6 = 1), cap_value takes the count and irq_o pulses three clocks after the input changes. The opposite edge is ignored. With bit 5 = 1, hs1 mirrors the synchronised capture input.
- R9: A control write with bit 7 = 0 and bit 0 = 0 during capture stops the timer at once. The next write then acts immediately.
- R10: During capture, a control write with bit 7 = 0 and bit 0 = 1 keeps capture active through the next wrap and its dead time, then stops the timer. While stopped this way, control writes with bit 0 = 1 are ignored until a write with bit 0 = 0.
- R11: In PWM mode with bit 6 set, hs2 is active from the duty match to the end of the cycle, except during the dead-time window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| hs1_o | output | 1 | First high-side output |
| hs2_o | output | 1 | Second high-side output |
| strobe_o | output | 1 | ADC strobe output |
| irq_o | output | 1 | Interrupt pulse |
| cap_value | output | 12 | Last captured count |

## Verification
The bench walks a PWM waveform clock by clock across a first cycle with no gap and a second cycle opened by a two-clock dead time. A design that inserted the gap in the wrong place, or counted the period off by one, would misplace the strobe, the interrupt or the duty edge. A control write is placed mid-cycle to confirm that the second output keeps running until the following boundary. An early apply would drop it too soon, and a readback of the applied value would not show the written byte. The capture tests time one edge against the last dead-time clock of a deferred exit, and then another against the clock just after it. A design that stopped at the wrap, or ignored the lockout, would lose the first capture or would start the timer on a write it must refuse.

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer #(
  parameter int CW  = 12,
  parameter int DTW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          cap_in,
  output logic          hs1_o,
  output logic          hs2_o,
  output logic          strobe_o,
  output logic          irq_o,
  output logic [CW-1:0] cap_value
);
  localparam int HW = CW - 8;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [7:0]     ctl_sw;
  logic [DTW-1:0] dt_q, dt_cnt;
  logic [2:0]     pol_q, sync;
  logic [CW-1:0]  per_q, duty_q, cnt, cap_q;
  logic           act_mode, act_run, act_c1, act_c2, lock, irq_q;

  wire running  = act_mode | act_run;
  wire pwm_run  = ~act_mode & act_run;
  wire [CW-1:0] top = act_mode ? CNT_MAX : per_q;
  wire ovf      = running && (cnt == top);
  wire dead     = dt_cnt != '0;
  wire bnd      = running && ((ovf && dt_q == '0) || dt_cnt == DTW'(1));
  wire ctl_we   = bus_wr && bus_addr == 3'd0;
  wire quick_ex = act_mode && !bus_wdata[7] && !bus_wdata[0];
  wire rise     = sync[1] & ~sync[2];
  wire fall     = ~sync[1] & sync[2];
  wire cap_hit  = act_mode && (act_c2 ? fall : rise);

  wire hs1_raw  = pwm_run ? (act_c1 && !dead && cnt < duty_q)
                          : (act_mode && act_c1 && sync[1]);
  wire hs2_raw  = pwm_run && act_c2 && !dead && cnt >= duty_q;
  wire strobe_int = !act_mode && ovf;

  assign hs1_o     = hs1_raw ^ pol_q[0];
  assign strobe_o  = (strobe_int & act_run) ^ pol_q[1];
  assign hs2_o     = hs2_raw ^ pol_q[2];
  assign irq_o     = irq_q;
  assign cap_value = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_q   <= '0;
      pol_q  <= '0;
      per_q  <= '1;
      duty_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        3'd1: dt_q <= bus_wdata[DTW-1:0];
        3'd2: pol_q <= bus_wdata[2:0];
        3'd3: per_q[7:0] <= bus_wdata;
        3'd4: per_q[CW-1:8] <= bus_wdata[HW-1:0];
        3'd5: duty_q[7:0] <= bus_wdata;
        3'd6: duty_q[CW-1:8] <= bus_wdata[HW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = ctl_sw;
      3'd1: bus_rdata = {{(8-DTW){1'b0}}, dt_q};
      3'd2: bus_rdata = {5'b0, pol_q};
      3'd3: bus_rdata = per_q[7:0];
      3'd4: bus_rdata = {{(8-HW){1'b0}}, per_q[CW-1:8]};
      3'd5: bus_rdata = duty_q[7:0];
      3'd6: bus_rdata = {{(8-HW){1'b0}}, duty_q[CW-1:8]};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sw   <= '0;
      act_mode <= 1'b0;
      act_run  <= 1'b0;
      act_c1   <= 1'b0;
      act_c2   <= 1'b0;
      lock     <= 1'b0;
    end else begin
      if (ctl_we) ctl_sw <= bus_wdata;
      if (ctl_we && !running) begin
        if (!(lock && bus_wdata[0])) begin
          lock     <= 1'b0;
          act_mode <= bus_wdata[7];
          act_c2   <= bus_wdata[6];
          act_c1   <= bus_wdata[5];
          act_run  <= bus_wdata[0];
        end
      end else if (ctl_we && quick_ex) begin
        act_mode <= 1'b0;
        act_run  <= 1'b0;
        act_c2   <= bus_wdata[6];
        act_c1   <= bus_wdata[5];
      end else if (bnd) begin
        act_c2 <= ctl_sw[6];
        act_c1 <= ctl_sw[5];
        if (act_mode && !ctl_sw[7] && ctl_sw[0]) begin
          act_mode <= 1'b0;
          act_run  <= 1'b0;
          lock     <= 1'b1;
        end else begin
          act_mode <= ctl_sw[7];
          act_run  <= ctl_sw[0];
        end
      end
    end
  end

  a_r4_hold_between_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !bnd && !ctl_we) |=> $stable({act_mode, act_run, act_c1, act_c2}));
  a_r10_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && ctl_we && bus_wdata[0]) |=> !running);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dt_cnt <= '0;
    end else if (!running) begin
      cnt    <= '0;
      dt_cnt <= '0;
    end else begin
      cnt    <= ovf ? '0 : cnt + 1'b1;
      dt_cnt <= ovf ? dt_q : (dead ? dt_cnt - 1'b1 : '0);
    end
  end

  a_r3_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_run && ovf && dt_q != '0 && !(bus_wr && bus_addr == 3'd2))
      |=> (hs1_o == pol_q[0] && hs2_o == pol_q[2]));
  a_r8_cap_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode && !ovf) |=> cnt == CW'($past(cnt) + 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sync  <= {sync[1:0], cap_in};
      irq_q <= (pwm_run && ovf) || cap_hit;
      if (cap_hit) cap_q <= cnt;
    end
  end

  a_r7_irq_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_run && ovf) |=> irq_o);
  a_r8_capture_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cap_value == $past(cnt) && irq_o));
endmodule

// File: tb/pwm_cap_timer_test.sv
`timescale 1ns/1ps
module pwm_cap_timer_test;
  logic clk = 0, rst_n = 0, bus_wr = 0, cap_in = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic hs1_o, hs2_o, strobe_o, irq_o;
  logic [11:0] cap_value;
  int total = 0, bad = 0;

  pwm_cap_timer uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .hs1_o(hs1_o),
    .hs2_o(hs2_o), .strobe_o(strobe_o), .irq_o(irq_o), .cap_value(cap_value));

  always #4 clk = ~clk;

  // {hs1, hs2, strobe, irq} per clock; period 9, duty 4, dead time 2
  localparam logic [3:0] WAVE [0:20] = '{
    4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b0100, 4'b0100, 4'b0100,
    4'b0100, 4'b0100, 4'b0110, 4'b0001, 4'b0000, 4'b1000, 4'b1000,
    4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0100, 4'b0110, 4'b0001};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    cap_in = 0; bus_wr = 0;
    @(negedge clk); rst_n = 0;
    step(2); rst_n = 1;
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    step(2);
    chk("R1 outputs", {hs1_o, hs2_o, strobe_o, irq_o}, 0);
    chk("R1 cap_value", cap_value, 0);
    rd(0, d); chk("R1 ctl", d, 0);
    rd(2, d); chk("R1 pol", d, 0);
    rd(4, d); chk("R1 period high", d, 8'h0F);
    rst_n = 1;

    wr(3, 9); wr(4, 0); wr(5, 4); wr(1, 8'hE2);
    rd(1, d); chk("R3 dt readback", d, 8'h02);
    wr(0, 8'h61);
    for (int k = 0; k <= 20; k++) begin
      chk($sformatf("R2 R3 R6 R7 R11 wave k=%0d", k), {hs1_o, hs2_o, strobe_o, irq_o}, WAVE[k]);
      if (k < 20) @(negedge clk);
    end
    wr(0, 8'h21);
    rd(0, d); chk("R4 readback written", d, 8'h21);
    step(2); chk("R4 hs2 still active", hs2_o, 1);
    step(8); chk("R4 hs1 after bound", hs1_o, 1);
    step(2); chk("R4 hs2 disabled", hs2_o, 0);

    do_reset();
    wr(2, 7);
    chk("R5 idle inverted", {hs1_o, hs2_o, strobe_o}, 3'b111);
    wr(3, 9); wr(4, 0); wr(5, 4); wr(0, 8'h21);
    chk("R5 hs1 active low", hs1_o, 0);
    chk("R5 hs2 disabled", hs2_o, 1);
    step(9);
    chk("R6 strobe active low", strobe_o, 0);
    chk("R5 hs1 inactive", hs1_o, 1);
    step(1);
    chk("R3 no dead time", hs1_o, 0);
    chk("R7 irq", irq_o, 1);

    do_reset();
    wr(0, 8'h80);
    step(5); cap_in = 1;
    step(3); chk("R8 rising cap", cap_value, 7); chk("R8 irq", irq_o, 1);
    step(1); chk("R8 irq one clock", irq_o, 0);
    cap_in = 0;
    step(3); chk("R8 falling ignored cap", cap_value, 7); chk("R8 falling ignored irq", irq_o, 0);

    do_reset();
    wr(0, 8'hE0);
    step(2); cap_in = 1;
    step(2); chk("R8 hs1 mirror", hs1_o, 1);
    step(1); chk("R8 rise ignored irq", irq_o, 0); chk("R8 rise ignored cap", cap_value, 0);
    step(1); cap_in = 0;
    step(3); chk("R8 falling cap", cap_value, 8); chk("R8 falling irq", irq_o, 1);

    do_reset();
    wr(5, 4); wr(0, 8'h80);
    step(5); wr(0, 8'h00);
    cap_in = 1;
    step(4); chk("R9 no capture irq", irq_o, 0); chk("R9 no capture", cap_value, 0);
    wr(0, 8'h21);
    chk("R9 restart immediate", hs1_o, 1);

    do_reset();
    wr(1, 3); wr(5, 4); wr(0, 8'h81);
    wr(0, 8'h01);
    cap_in = 1;
    step(3); chk("R10 still capturing", cap_value, 4); chk("R10 irq", irq_o, 1);
    cap_in = 0;
    step(4091); cap_in = 1;
    step(3); chk("R10 capture in dead time", cap_value, 2); chk("R10 irq dead time", irq_o, 1);
    cap_in = 0;
    step(1); cap_in = 1;
    step(3); chk("R10 stopped irq", irq_o, 0); chk("R10 stopped cap", cap_value, 2);
    rd(0, d); chk("R10 readback", d, 8'h01);
    wr(0, 8'h61);
    chk("R10 locked", hs1_o, 0);
    step(2); chk("R10 still locked", hs1_o, 0);
    wr(0, 8'h00); wr(0, 8'h21);
    chk("R10 unlocked run", hs1_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule